// File: doc/BRIEF.md
# Clock Source Settle Controller

This block manages the core clock source of a small microcontroller. It holds an eight-bit configuration register that software writes and reads back. It moves the core between an internal oscillator and an external resonator or crystal, and it brings the core back from suspend. Whenever a source change or a wake-up is under way, the block holds the core clock gated. It releases the clock only after a settle time has passed, and it signals this with a clock-ready output that doubles as the gate enable.

The external oscillator reports that it is running through an oscillator-valid strobe. The settle time for the external source starts only after that strobe and is picked by a register bit: a long window suits a crystal and a short one suits a ceramic resonator. A wake-up that stays on the internal oscillator uses a much shorter fixed window and does not wait for the strobe. All windows are counted on the 12 MHz reference clock that also runs the block.

Top module: `clksrc_settle_ctrl`

## Requirements
- R1: After reset the register reads 0x00, clk_ready is 1, sel_ext is 0, and int_clk_out_dis, lvr_dis and wake_adj are all 0.
- R2: All eight register bits can be written and read back. Bit 0 enables the external source, bit 1 drives int_clk_out_dis, bit 3 drives lvr_dis, bits 6:4 drive wake_adj, bit 7 selects the long settle window, and bit 2 is stored and readable only. Without a write the register holds its value.
- R3: When bit 0 becomes 1 while running on the internal source, clk_ready goes low one cycle after the register update. It stays low, with sel_ext 0, for as long as oscillator-valid has not been seen.
- R4: With bit 7 at 0, clk_ready and sel_ext both rise exactly 1536 cycles after the clock edge that samples oscillator-valid.
- R5: With bit 7 at 1, the same window is 48000 cycles.
- R6: Clearing bit 0 while running on the external source drops sel_ext one cycle after the register update. clk_ready stays 1 throughout.
- R7: A suspend request drives clk_ready and sel_ext low at the first clock edge that samples it. They stay low until a wake request is taken.
- R8: A wake request while suspended with bit 0 at 0 raises clk_ready exactly 96 cycles after the edge that samples it. It needs no oscillator-valid, it ignores bit 7, and sel_ext stays 0.
- R9: A wake request while suspended with bit 0 at 1 keeps clk_ready low until oscillator-valid arrives. It then applies the window chosen by bit 7 and ends with sel_ext at 1.
- R10: The settle window length is fixed when a transition starts. A write to bit 7 during a window does not change that window.
- R11: Oscillator-valid and wake requests have no effect while the core runs on the internal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| osc_valid | input | 1 | External oscillator running strobe |
| suspend_req | input | 1 | Suspend request pulse |
| wake_req | input | 1 | Wake request pulse |
| clk_ready | output | 1 | Core clock released (gate enable) |
| sel_ext | output | 1 | Core clock taken from the external source |
| int_clk_out_dis | output | 1 | Internal clock output pin disabled |
| lvr_dis | output | 1 | Low-voltage reset disabled |
| wake_adj | output | 3 | Wake-up timer adjust value |

## Verification
A wrong sequencer state shows at once at the ports. clk_ready stays high when it should fall, or sel_ext moves in the wrong cycle relative to the register write or the suspend pulse, and these are sampled one cycle after the triggering edge. A settle counter that loads the wrong length, or that reads bit 7 after the start of a window, shifts the rising edge of clk_ready by at least one cycle. The bench counts every cycle from the sampling edge, so an off-by-one becomes visible when the window closes, after at most 48000 cycles. A register bit wired to the wrong output is caught on the read-back and the output pins in the cycle after the write.

// File: rtl/cksw_pkg.sv
package cksw_pkg;
   localparam int CFG_W        = 8;
   localparam int BIT_EXT_EN   = 0;
   localparam int BIT_INT_ODIS = 1;
   localparam int BIT_LVR_DIS  = 3;
   localparam int WADJ_LO      = 4;
   localparam int WADJ_W       = 3;
   localparam int BIT_LONG_DLY = 7;

   typedef enum logic [2:0] {
      ST_RUN_INT,
      ST_WAIT_OSC,
      ST_SETTLE,
      ST_RUN_EXT,
      ST_SLEEP
   } seq_state_t;

   typedef enum logic [1:0] {
      DLY_WAKE,
      DLY_SHORT,
      DLY_LONG
   } dly_sel_t;
endpackage

// File: rtl/cksw_cfg_reg.sv
module cksw_cfg_reg
   import cksw_pkg::*;
#(
   parameter logic [CFG_W-1:0] RST_VAL = '0,
   parameter logic [CFG_W-1:0] WR_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] q
);

   for (genvar i = 0; i < CFG_W; i++) begin : g_bit
      if (WR_MASK[i]) begin : g_rw
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  bit_q <= RST_VAL[i];
            else if (we) bit_q <= wdata[i];
         end
         assign q[i] = bit_q;
      end else begin : g_ro
         assign q[i] = RST_VAL[i];
      end
   end

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q)); // R2

endmodule

// File: rtl/cksw_settle_timer.sv
module cksw_settle_timer
   import cksw_pkg::*;
#(
   parameter int LONG_CYC   = 48000,
   parameter int SHORT_CYC  = 1536,
   parameter int WAKE_CYC   = 96,
   parameter bit DOWN_COUNT = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     abort,
   input  dly_sel_t sel,
   output logic     busy,
   output logic     done
);

   localparam int MAX_CYC = (LONG_CYC > SHORT_CYC)
                          ? ((LONG_CYC > WAKE_CYC) ? LONG_CYC : WAKE_CYC)
                          : ((SHORT_CYC > WAKE_CYC) ? SHORT_CYC : WAKE_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC);

   if (!(WAKE_CYC >= 2 && WAKE_CYC < SHORT_CYC && SHORT_CYC < LONG_CYC)) begin : g_bad_len
      $error("settle windows must satisfy 2 <= wake < short < long");
   end

   logic [CNT_W-1:0] load_val;

   always_comb begin
      case (sel)
         DLY_LONG:  load_val = CNT_W'(LONG_CYC - 1);
         DLY_SHORT: load_val = CNT_W'(SHORT_CYC - 1);
         default:   load_val = CNT_W'(WAKE_CYC - 1);
      endcase
   end

   if (DOWN_COUNT) begin : g_down
      logic [CNT_W-1:0] cnt_q;
      logic             busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (abort) begin
            busy_q <= 1'b0;
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= load_val;
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end
      end
      assign busy = busy_q;
      assign done = busy_q && (cnt_q == '0);

      AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_q && cnt_q == '0 && !start) |=> !busy_q); // R4
   end else begin : g_up
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] term_q;
      logic             busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            term_q <= '0;
         end else if (abort) begin
            busy_q <= 1'b0;
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            term_q <= load_val;
         end else if (busy_q) begin
            if (cnt_q == term_q) busy_q <= 1'b0;
            else                 cnt_q  <= cnt_q + 1'b1;
         end
      end
      assign busy = busy_q;
      assign done = busy_q && (cnt_q == term_q);

      AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
         busy_q |-> (cnt_q <= term_q)); // R10
   end

   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy); // R10

endmodule

// File: rtl/cksw_sequencer.sv
module cksw_sequencer
   import cksw_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_ext_en,
   input  logic     cfg_long_dly,
   input  logic     osc_valid,
   input  logic     suspend_req,
   input  logic     wake_req,
   input  logic     tmr_done,
   output logic     tmr_start,
   output logic     tmr_abort,
   output dly_sel_t tmr_sel,
   output logic     clk_ready,
   output logic     sel_ext
);

   seq_state_t state_q, state_d;
   dly_sel_t   pend_q, pend_d;
   logic       tgt_ext_q, tgt_ext_d;
   logic       ready_q, ready_d;
   logic       sel_q, sel_d;
   dly_sel_t   ext_sel;

   assign ext_sel = cfg_long_dly ? DLY_LONG : DLY_SHORT;

   always_comb begin
      state_d   = state_q;
      pend_d    = pend_q;
      tgt_ext_d = tgt_ext_q;
      ready_d   = ready_q;
      sel_d     = sel_q;
      tmr_start = 1'b0;
      tmr_abort = 1'b0;
      tmr_sel   = pend_q;
      case (state_q)
         ST_RUN_INT: begin
            if (suspend_req) begin
               state_d = ST_SLEEP;
               ready_d = 1'b0;
               sel_d   = 1'b0;
            end else if (cfg_ext_en) begin
               state_d   = ST_WAIT_OSC;
               ready_d   = 1'b0;
               pend_d    = ext_sel;
               tgt_ext_d = 1'b1;
            end
         end
         ST_RUN_EXT: begin
            if (suspend_req) begin
               state_d = ST_SLEEP;
               ready_d = 1'b0;
               sel_d   = 1'b0;
            end else if (!cfg_ext_en) begin
               state_d = ST_RUN_INT;
               sel_d   = 1'b0;
            end
         end
         ST_WAIT_OSC: begin
            if (suspend_req) begin
               state_d = ST_SLEEP;
            end else if (osc_valid) begin
               state_d   = ST_SETTLE;
               tmr_start = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (suspend_req) begin
               state_d   = ST_SLEEP;
               tmr_abort = 1'b1;
            end else if (tmr_done) begin
               state_d = tgt_ext_q ? ST_RUN_EXT : ST_RUN_INT;
               sel_d   = tgt_ext_q;
               ready_d = 1'b1;
            end
         end
         ST_SLEEP: begin
            if (wake_req) begin
               if (cfg_ext_en) begin
                  state_d   = ST_WAIT_OSC;
                  pend_d    = ext_sel;
                  tgt_ext_d = 1'b1;
               end else begin
                  state_d   = ST_SETTLE;
                  pend_d    = DLY_WAKE;
                  tgt_ext_d = 1'b0;
                  tmr_start = 1'b1;
                  tmr_sel   = DLY_WAKE;
               end
            end
         end
         default: begin
            state_d = ST_RUN_INT;
            ready_d = 1'b1;
            sel_d   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN_INT;
         pend_q    <= DLY_SHORT;
         tgt_ext_q <= 1'b0;
         ready_q   <= 1'b1;
         sel_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         pend_q    <= pend_d;
         tgt_ext_q <= tgt_ext_d;
         ready_q   <= ready_d;
         sel_q     <= sel_d;
      end
   end

   assign clk_ready = ready_q;
   assign sel_ext   = sel_q;

   AST_SUSPEND_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req |=> (!ready_q && !sel_q)); // R7
   AST_EXT_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q |-> ready_q); // R4
   AST_WAIT_HOLDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_OSC && !osc_valid && !suspend_req) |=> !ready_q); // R3

endmodule

// File: rtl/clksrc_settle_ctrl.sv
module clksrc_settle_ctrl
   import cksw_pkg::*;
#(
   parameter int               LONG_CYC    = 48000,
   parameter int               SHORT_CYC   = 1536,
   parameter int               WAKE_CYC    = 96,
   parameter bit               DOWN_COUNT  = 1'b1,
   parameter logic [CFG_W-1:0] CFG_RST     = '0,
   parameter logic [CFG_W-1:0] CFG_WR_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              osc_valid,
   input  logic              suspend_req,
   input  logic              wake_req,
   output logic              clk_ready,
   output logic              sel_ext,
   output logic              int_clk_out_dis,
   output logic              lvr_dis,
   output logic [WADJ_W-1:0] wake_adj
);

   logic [CFG_W-1:0] cfg_q;
   logic             tmr_start, tmr_abort, tmr_busy, tmr_done;
   dly_sel_t         tmr_sel;

   cksw_cfg_reg #(
      .RST_VAL (CFG_RST),
      .WR_MASK (CFG_WR_MASK)
   ) i_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   cksw_sequencer i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_ext_en   (cfg_q[BIT_EXT_EN]),
      .cfg_long_dly (cfg_q[BIT_LONG_DLY]),
      .osc_valid    (osc_valid),
      .suspend_req  (suspend_req),
      .wake_req     (wake_req),
      .tmr_done     (tmr_done),
      .tmr_start    (tmr_start),
      .tmr_abort    (tmr_abort),
      .tmr_sel      (tmr_sel),
      .clk_ready    (clk_ready),
      .sel_ext      (sel_ext)
   );

   cksw_settle_timer #(
      .LONG_CYC   (LONG_CYC),
      .SHORT_CYC  (SHORT_CYC),
      .WAKE_CYC   (WAKE_CYC),
      .DOWN_COUNT (DOWN_COUNT)
   ) i_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .abort (tmr_abort),
      .sel   (tmr_sel),
      .busy  (tmr_busy),
      .done  (tmr_done)
   );

   assign cfg_rdata       = cfg_q;
   assign int_clk_out_dis = cfg_q[BIT_INT_ODIS];
   assign lvr_dis         = cfg_q[BIT_LVR_DIS];
   assign wake_adj        = cfg_q[WADJ_LO +: WADJ_W];

   AST_BUSY_GATES_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_busy |-> !clk_ready); // R3
   AST_READY_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ready) |-> $past(tmr_done)); // R4

endmodule

// File: tb/test_clksrc_settle_ctrl.sv
module test_clksrc_settle_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       osc_valid = 1'b0;
   logic       suspend_req = 1'b0;
   logic       wake_req = 1'b0;
   logic       clk_ready, sel_ext, int_clk_out_dis, lvr_dis;
   logic [2:0] wake_adj;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   clksrc_settle_ctrl i_clksrc_settle_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_we          (cfg_we),
      .cfg_wdata       (cfg_wdata),
      .cfg_rdata       (cfg_rdata),
      .osc_valid       (osc_valid),
      .suspend_req     (suspend_req),
      .wake_req        (wake_req),
      .clk_ready       (clk_ready),
      .sel_ext         (sel_ext),
      .int_clk_out_dis (int_clk_out_dis),
      .lvr_dis         (lvr_dis),
      .wake_adj        (wake_adj)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_osc();
      osc_valid = 1'b1; @(negedge clk); osc_valid = 1'b0;
   endtask

   task automatic pulse_suspend();
      suspend_req = 1'b1; @(negedge clk); suspend_req = 1'b0;
   endtask

   task automatic pulse_wake();
      wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
   endtask

   // Called at the negedge after the sampling edge; returns edges until ready
   task automatic wait_ready(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!clk_ready && n < 60000);
   endtask

   task automatic t_reset();
      chk("R1", "rdata", cfg_rdata, 0);
      chk("R1", "clk_ready", clk_ready, 1);
      chk("R1", "sel_ext", sel_ext, 0);
      chk("R1", "pins", {int_clk_out_dis, lvr_dis, wake_adj}, 0);
   endtask

   task automatic t_regs();
      do_write(8'h5E);
      chk("R2", "rdata 5E", cfg_rdata, 8'h5E);
      chk("R2", "int_clk_out_dis", int_clk_out_dis, 1);
      chk("R2", "lvr_dis", lvr_dis, 1);
      chk("R2", "wake_adj", wake_adj, 5);
      chk("R2", "no switch on bits 6:1", clk_ready, 1);
      do_write(8'hA4);
      repeat (3) @(negedge clk);
      chk("R2", "rdata A4 held", cfg_rdata, 8'hA4);
      chk("R2", "pins A4", {int_clk_out_dis, lvr_dis, wake_adj}, 5'b00010);
      do_write(8'h00);
   endtask

   task automatic t_ignored();
      pulse_osc();
      pulse_wake();
      repeat (3) @(negedge clk);
      chk("R11", "ready after stray strobes", clk_ready, 1);
      chk("R11", "sel after stray strobes", sel_ext, 0);
   endtask

   task automatic t_switch_short();
      int n;
      do_write(8'h01);
      @(negedge clk);
      chk("R3", "ready low after start", clk_ready, 0);
      repeat (40) @(negedge clk);
      chk("R3", "ready held without osc", clk_ready, 0);
      chk("R3", "sel held without osc", sel_ext, 0);
      pulse_osc();
      wait_ready(n);
      chk("R4", "short window cycles", n, 1536);
      chk("R4", "sel with ready", sel_ext, 1);
   endtask

   task automatic t_back_internal();
      do_write(8'h00);
      chk("R6", "sel before switch-back", sel_ext, 1);
      @(negedge clk);
      chk("R6", "sel after switch-back", sel_ext, 0);
      chk("R6", "ready kept", clk_ready, 1);
   endtask

   task automatic t_wake_int();
      int n;
      do_write(8'h80);
      pulse_suspend();
      chk("R7", "ready at suspend", clk_ready, 0);
      repeat (10) @(negedge clk);
      chk("R7", "ready held in suspend", clk_ready, 0);
      pulse_wake();
      wait_ready(n);
      chk("R8", "internal wake cycles", n, 96);
      chk("R8", "sel stays internal", sel_ext, 0);
   endtask

   task automatic t_long();
      int n;
      do_write(8'h81);
      @(negedge clk);
      pulse_osc();
      wait_ready(n);
      chk("R5", "long window cycles", n, 48000);
      chk("R5", "sel after long", sel_ext, 1);
   endtask

   task automatic t_wake_ext();
      int n;
      do_write(8'h01);
      chk("R6", "ext kept with bit0 set", sel_ext, 1);
      pulse_suspend();
      chk("R7", "ready at suspend ext", clk_ready, 0);
      chk("R7", "sel at suspend ext", sel_ext, 0);
      pulse_wake();
      repeat (30) @(negedge clk);
      chk("R9", "ready waits for osc", clk_ready, 0);
      pulse_osc();
      wait_ready(n);
      chk("R9", "ext wake cycles", n, 1536);
      chk("R9", "ends external", sel_ext, 1);
   endtask

   task automatic t_write_during();
      int n;
      do_write(8'h00);
      @(negedge clk);
      do_write(8'h01);
      @(negedge clk);
      pulse_osc();
      n = 0;
      repeat (100) begin @(negedge clk); n++; end
      do_write(8'h81);
      n++;
      while (!clk_ready && n < 60000) begin @(negedge clk); n++; end
      chk("R10", "window fixed at start", n, 1536);
      chk("R10", "rdata keeps new write", cfg_rdata, 8'h81);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_ignored();
      t_switch_short();
      t_back_internal();
      t_wake_int();
      t_long();
      t_wake_ext();
      t_write_during();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule